// File: doc/BRIEF.md
# File-Indexed Storage Command Translator

This block converts file-level storage requests into sector-level commands for a disk host controller. A user asks to format the disk, to write a run of files or to read a run of files. A file is named by its number and a run by its length in files. The block works out the first sector and the sector count, then starts the host command. Every file has the same size, chosen by a 3-bit size code. That size is always a power of two, so all address arithmetic reduces to shifts.

After reset the block waits for the host controller to finish its own start-up. It then captures the disk size that the host reports and derives the number of whole files the disk can hold. While a command runs, busy stays high. It falls only after the host controller has taken the command and then reported that it has finished. Inputs that are out of range are passed through without any check.

Top module: `file_cmd_xlate`

## Requirements
- R1: While synchronous active-low reset is held, and after it until the host has reported ready, busy is 1 and host_req is 0.
- R2: Once host_busy is seen low after reset, the disk size on host_sectors is captured and busy falls two clock edges later. From then on max_files is valid.
- R3: The sectors per file are 2^(16+size_code), where a sector is 512 bytes: code 0 is 32 MiB and code 6 is 2048 MiB. The reserved code 7 behaves as code 6.
- R4: max_files equals (captured sectors − BASE) shifted right by (16+code). It saturates at 65535, is 0 when the disk holds fewer than BASE sectors, and follows size_code without a new reset.
- R5: A write-file request (ucmd 2'b10) accepted while idle presents host_cmd 2'b01 with host_req 1 and busy 1 on the next cycle. It sets host_addr = BASE + first_file × sectors-per-file and host_len = file_count × sectors-per-file.
- R6: A read-file request (ucmd 2'b11) presents host_cmd 2'b00 with the same address and length rules as R5.
- R7: A format request (ucmd 2'b00) presents host_cmd 2'b01, host_addr 0 and host_len FMT_SECTORS. first_file and file_count have no effect on it.
- R8: The reserved command code 2'b01 is ignored: busy stays 0 and host_req stays 0.
- R9: req while busy is ignored: the host outputs do not change and no extra command is issued.
- R10: host_req stays 1, and host_cmd, host_addr and host_len stay stable, until host_busy is seen high. host_req then drops on the next edge.
- R11: busy falls on the edge after host_busy is seen low while the command runs. A request held across that edge is accepted on the following edge, not on the finishing edge.
- R12: first_file and file_count are not range-checked: a run reaching beyond max_files is still issued with the R5 arithmetic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the host controller |
| rst_n | input | 1 | Synchronous reset, active low |
| size_code | input | 3 | File size code (R3) |
| req | input | 1 | Command request, honoured only while busy is 0 |
| ucmd | input | 2 | 00 format, 01 reserved, 10 write files, 11 read files |
| first_file | input | 16 | Number of the first file of the run |
| file_count | input | 16 | Number of files in the run |
| busy | output | 1 | Block is initializing or running a command |
| max_files | output | 16 | Number of files the disk can hold |
| host_cmd | output | 2 | Host operation: 00 read sectors, 01 write sectors |
| host_addr | output | 48 | Start sector for the host |
| host_len | output | 48 | Sector count for the host |
| host_req | output | 1 | Host command request |
| host_busy | input | 1 | Host controller busy or not yet ready |
| host_sectors | input | 48 | Disk size in sectors reported by the host |

## Verification
Two events can land on one edge: the finish of a running command, when host_busy drops, and a new request. The new request is raised while busy is still high and held through the cycle in which the host reports done. On the finishing edge the bench expects busy to fall with host_req still low. On the next edge it expects the new command to be issued with its own address. A second pairing is a size_code change while a command is outstanding: the issued address must keep the latched value while max_files moves at once.

// File: rtl/fcx_pkg.sv
package fcx_pkg;

  typedef enum logic [1:0] {
    UC_FORMAT = 2'b00,
    UC_RSVD   = 2'b01,
    UC_WRITE  = 2'b10,
    UC_READ   = 2'b11
  } ucmd_e;

  typedef enum logic [2:0] {
    ST_WAIT_HOST = 3'd0,
    ST_CAPTURE   = 3'd1,
    ST_IDLE      = 3'd2,
    ST_START     = 3'd3,
    ST_RUN       = 3'd4
  } fcx_state_e;

  localparam logic [1:0] HOST_RD = 2'b00;
  localparam logic [1:0] HOST_WR = 2'b01;

endpackage

// File: rtl/fcx_size_decode.sv
module fcx_size_decode #(
  parameter int SIZE_W      = 3,
  parameter int EXP_W       = 5,
  parameter int EXP_MIN     = 16,
  parameter int CODE_TOP    = 6,
  parameter bit RSVD_AS_TOP = 1'b1
) (
  input  logic [SIZE_W-1:0] code,
  output logic [EXP_W-1:0]  sect_exp
);

  logic [SIZE_W-1:0] eff_code;

  generate
    if (RSVD_AS_TOP) begin : g_clamp
      assign eff_code = (code > SIZE_W'(CODE_TOP)) ? SIZE_W'(CODE_TOP) : code;
    end else begin : g_pass
      assign eff_code = code;
    end
  endgenerate

  function automatic logic [EXP_W-1:0] to_exp(input logic [SIZE_W-1:0] c);
    return EXP_W'(EXP_MIN) + EXP_W'(c);
  endfunction

  assign sect_exp = to_exp(eff_code);

endmodule

// File: rtl/fcx_capacity.sv
module fcx_capacity #(
  parameter int          SECT_W = 48,
  parameter int          FNUM_W = 16,
  parameter int          EXP_W  = 5,
  parameter int unsigned BASE   = 32768
) (
  input  logic [SECT_W-1:0] disk_sectors,
  input  logic [EXP_W-1:0]  sect_exp,
  output logic [FNUM_W-1:0] max_files
);

  localparam longint unsigned MAXF = (64'd1 << FNUM_W) - 64'd1;

  function automatic logic [FNUM_W-1:0] files_fit(input logic [SECT_W-1:0] s,
                                                   input logic [EXP_W-1:0]  e);
    logic [SECT_W-1:0] q;
    if (s < SECT_W'(BASE)) return '0;
    q = (s - SECT_W'(BASE)) >> e;
    if (q > SECT_W'(MAXF)) return FNUM_W'(MAXF);
    return q[FNUM_W-1:0];
  endfunction

  assign max_files = files_fit(disk_sectors, sect_exp);

endmodule

// File: rtl/fcx_addr_gen.sv
module fcx_addr_gen
  import fcx_pkg::*;
#(
  parameter int          SECT_W      = 48,
  parameter int          FNUM_W      = 16,
  parameter int          EXP_W       = 5,
  parameter int unsigned BASE        = 32768,
  parameter int unsigned FMT_SECTORS = 8192
) (
  input  ucmd_e             ucmd,
  input  logic [FNUM_W-1:0] first_file,
  input  logic [FNUM_W-1:0] file_count,
  input  logic [EXP_W-1:0]  sect_exp,
  output logic [SECT_W-1:0] addr,
  output logic [SECT_W-1:0] len,
  output logic [1:0]        hcmd
);

  function automatic logic [SECT_W-1:0] run_start(input logic [FNUM_W-1:0] f,
                                                   input logic [EXP_W-1:0]  e);
    return SECT_W'(BASE) + (SECT_W'(f) << e);
  endfunction

  function automatic logic [SECT_W-1:0] run_len(input logic [FNUM_W-1:0] n,
                                                 input logic [EXP_W-1:0]  e);
    return SECT_W'(n) << e;
  endfunction

  always_comb begin
    case (ucmd)
      UC_FORMAT: begin
        addr = '0;
        len  = SECT_W'(FMT_SECTORS);
        hcmd = HOST_WR;
      end
      UC_WRITE: begin
        addr = run_start(first_file, sect_exp);
        len  = run_len(file_count, sect_exp);
        hcmd = HOST_WR;
      end
      default: begin
        addr = run_start(first_file, sect_exp);
        len  = run_len(file_count, sect_exp);
        hcmd = HOST_RD;
      end
    endcase
  end

endmodule

// File: rtl/fcx_ctrl.sv
module fcx_ctrl
  import fcx_pkg::*;
#(
  parameter int SECT_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  ucmd_e             ucmd,
  input  logic              host_busy,
  input  logic [SECT_W-1:0] host_sectors,
  input  logic [SECT_W-1:0] next_addr,
  input  logic [SECT_W-1:0] next_len,
  input  logic [1:0]        next_hcmd,
  output logic              busy,
  output logic              host_req,
  output logic [SECT_W-1:0] host_addr,
  output logic [SECT_W-1:0] host_len,
  output logic [1:0]        host_cmd,
  output logic [SECT_W-1:0] cap_q,
  output logic              issue_evt,
  output logic              done_evt
);

  fcx_state_e st;

  assign issue_evt = (st == ST_IDLE) && req && (ucmd != UC_RSVD);
  assign done_evt  = (st == ST_RUN) && !host_busy;
  assign busy      = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_WAIT_HOST;
      host_req  <= 1'b0;
      host_addr <= '0;
      host_len  <= '0;
      host_cmd  <= HOST_RD;
      cap_q     <= '0;
    end else begin
      case (st)
        ST_WAIT_HOST: if (!host_busy) st <= ST_CAPTURE;
        ST_CAPTURE: begin
          cap_q <= host_sectors;
          st    <= ST_IDLE;
        end
        ST_IDLE: if (issue_evt) begin
          host_addr <= next_addr;
          host_len  <= next_len;
          host_cmd  <= next_hcmd;
          host_req  <= 1'b1;
          st        <= ST_START;
        end
        ST_START: if (host_busy) begin
          host_req <= 1'b0;
          st       <= ST_RUN;
        end
        ST_RUN: if (done_evt) st <= ST_IDLE;
        default: st <= ST_WAIT_HOST;
      endcase
    end
  end

endmodule

// File: rtl/file_cmd_xlate.sv
module file_cmd_xlate
  import fcx_pkg::*;
#(
  parameter int          SIZE_W      = 3,
  parameter int          FNUM_W      = 16,
  parameter int          SECT_W      = 48,
  parameter int          EXP_MIN     = 16,
  parameter int          CODE_TOP    = 6,
  parameter int unsigned BASE        = 32768,
  parameter int unsigned FMT_SECTORS = 8192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        size_code,
  input  logic              req,
  input  logic [1:0]        ucmd,
  input  logic [15:0]       first_file,
  input  logic [15:0]       file_count,
  output logic              busy,
  output logic [15:0]       max_files,
  output logic [1:0]        host_cmd,
  output logic [47:0]       host_addr,
  output logic [47:0]       host_len,
  output logic              host_req,
  input  logic              host_busy,
  input  logic [47:0]       host_sectors
);

  localparam int EXP_W = $clog2(EXP_MIN + (1 << SIZE_W) + 1);

  logic [EXP_W-1:0]  sect_exp;
  logic [SECT_W-1:0] next_addr;
  logic [SECT_W-1:0] next_len;
  logic [1:0]        next_hcmd;
  logic [SECT_W-1:0] cap_q;
  logic              issue_evt;
  logic              done_evt;
  ucmd_e             ucmd_t;

  assign ucmd_t = ucmd_e'(ucmd);

  fcx_size_decode #(
    .SIZE_W(SIZE_W), .EXP_W(EXP_W), .EXP_MIN(EXP_MIN),
    .CODE_TOP(CODE_TOP), .RSVD_AS_TOP(1'b1)
  ) i_dec (
    .code(size_code), .sect_exp(sect_exp)
  );

  fcx_capacity #(
    .SECT_W(SECT_W), .FNUM_W(FNUM_W), .EXP_W(EXP_W), .BASE(BASE)
  ) i_cap (
    .disk_sectors(cap_q), .sect_exp(sect_exp), .max_files(max_files)
  );

  fcx_addr_gen #(
    .SECT_W(SECT_W), .FNUM_W(FNUM_W), .EXP_W(EXP_W),
    .BASE(BASE), .FMT_SECTORS(FMT_SECTORS)
  ) i_agen (
    .ucmd(ucmd_t), .first_file(first_file), .file_count(file_count),
    .sect_exp(sect_exp), .addr(next_addr), .len(next_len), .hcmd(next_hcmd)
  );

  fcx_ctrl #(.SECT_W(SECT_W)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .ucmd(ucmd_t),
    .host_busy(host_busy), .host_sectors(host_sectors),
    .next_addr(next_addr), .next_len(next_len), .next_hcmd(next_hcmd),
    .busy(busy), .host_req(host_req), .host_addr(host_addr),
    .host_len(host_len), .host_cmd(host_cmd), .cap_q(cap_q),
    .issue_evt(issue_evt), .done_evt(done_evt)
  );

endmodule

// File: rtl/fcx_checker.sv
module fcx_checker #(
  parameter int          SECT_W      = 48,
  parameter int          FNUM_W      = 16,
  parameter int unsigned BASE        = 32768,
  parameter int unsigned FMT_SECTORS = 8192
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic [1:0]        ucmd,
  input logic              busy,
  input logic              host_req,
  input logic              host_busy,
  input logic [SECT_W-1:0] host_addr,
  input logic [SECT_W-1:0] host_len,
  input logic [1:0]        host_cmd,
  input logic [SECT_W-1:0] cap_q,
  input logic [FNUM_W-1:0] max_files,
  input logic              issue_evt,
  input logic              done_evt
);

  p_busy_in_reset_r1: assert property (@(posedge clk)
    !rst_n |=> busy && !host_req);

  p_small_disk_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_q < SECT_W'(BASE) |-> max_files == '0);

  p_req_means_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    host_req |-> busy);

  p_format_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    issue_evt && ucmd == 2'b00 |=> host_addr == '0 && host_len == SECT_W'(FMT_SECTORS)
                                   && host_cmd == 2'b01);

  p_reserved_dropped_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && req && ucmd == 2'b01 |=> !busy && !host_req);

  p_issue_from_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_req) |-> $past(!busy));

  p_hold_until_taken_r10: assert property (@(posedge clk) disable iff (!rst_n)
    host_req && !host_busy |=> host_req && $stable(host_addr) && $stable(host_len)
                               && $stable(host_cmd));

  p_drop_after_taken_r10: assert property (@(posedge clk) disable iff (!rst_n)
    host_req && host_busy |=> !host_req);

  p_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> !busy && !host_req);

endmodule

bind file_cmd_xlate fcx_checker #(
  .SECT_W(SECT_W), .FNUM_W(FNUM_W), .BASE(BASE), .FMT_SECTORS(FMT_SECTORS)
) i_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .ucmd(ucmd), .busy(busy),
  .host_req(host_req), .host_busy(host_busy), .host_addr(host_addr),
  .host_len(host_len), .host_cmd(host_cmd), .cap_q(cap_q),
  .max_files(max_files), .issue_evt(issue_evt), .done_evt(done_evt)
);

// File: tb/test_file_cmd_xlate.sv
module test_file_cmd_xlate;

  localparam longint unsigned BASE_S = 32768;
  localparam longint unsigned FMT_S  = 8192;
  localparam longint unsigned DISK_A = 48'd600_000_000;

  // vector: size_code[36:34], ucmd[33:32], first[31:16], count[15:0]
  localparam logic [36:0] VEC [8] = '{
    {3'd0, 2'b10, 16'd0,     16'd1},
    {3'd1, 2'b10, 16'd5,     16'd3},
    {3'd2, 2'b11, 16'd17,    16'd2},
    {3'd3, 2'b11, 16'd100,   16'd7},
    {3'd4, 2'b10, 16'd40,    16'd9},
    {3'd5, 2'b00, 16'd1234,  16'd55},
    {3'd7, 2'b11, 16'd3,     16'd4},
    {3'd6, 2'b10, 16'd60000, 16'd100}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  size_code = 3'd0;
  logic        req = 1'b0;
  logic [1:0]  ucmd = 2'b00;
  logic [15:0] first_file = '0;
  logic [15:0] file_count = '0;
  logic        busy;
  logic [15:0] max_files;
  logic [1:0]  host_cmd;
  logic [47:0] host_addr;
  logic [47:0] host_len;
  logic        host_req;
  logic        host_busy = 1'b1;
  logic [47:0] host_sectors = DISK_A;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  finished = 1'b0;

  always #5 clk = ~clk;

  file_cmd_xlate i_file_cmd_xlate (
    .clk(clk), .rst_n(rst_n), .size_code(size_code), .req(req), .ucmd(ucmd),
    .first_file(first_file), .file_count(file_count), .busy(busy),
    .max_files(max_files), .host_cmd(host_cmd), .host_addr(host_addr),
    .host_len(host_len), .host_req(host_req), .host_busy(host_busy),
    .host_sectors(host_sectors)
  );

  function automatic longint unsigned file_sectors(input int code);
    int c = (code == 7) ? 6 : code;
    return (longint'(32) * 1024 * 1024 * (longint'(1) << c)) / 512;
  endfunction

  function automatic longint unsigned expect_cap(input longint unsigned disk, input int code);
    longint unsigned q;
    if (disk < BASE_S) return 0;
    q = (disk - BASE_S) / file_sectors(code);
    return (q > 65535) ? 65535 : q;
  endfunction

  task automatic chk(input string tag, input longint unsigned act, input longint unsigned exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_init(input longint unsigned disk);
    @(negedge clk);
    rst_n = 1'b0; host_busy = 1'b1; host_sectors = 48'(disk); req = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", busy, 1);
    chk("R1 host_req in reset", host_req, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 busy while host not ready", busy, 1);
    host_busy = 1'b0;
    @(negedge clk);
    chk("R2 busy one edge after ready", busy, 1);
    @(negedge clk);
    chk("R2 busy falls two edges after ready", busy, 0);
  endtask

  task automatic run_cmd(input string tag, input logic [2:0] code, input logic [1:0] c,
                         input logic [15:0] f, input logic [15:0] n);
    longint unsigned ea, el, ec;
    if (c == 2'b00) begin ea = 0; el = FMT_S; ec = 1; end
    else begin
      ea = BASE_S + longint'(f) * file_sectors(code);
      el = longint'(n) * file_sectors(code);
      ec = (c == 2'b10) ? 1 : 0;
    end
    size_code = code; ucmd = c; first_file = f; file_count = n; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    chk({tag, " busy after accept"}, busy, 1);
    chk({tag, " host_req"}, host_req, 1);
    chk({tag, " host_cmd"}, host_cmd, ec);
    chk({tag, " host_addr"}, host_addr, ea);
    chk({tag, " host_len"}, host_len, el);
    @(negedge clk);
    chk("R10 host_req held while host idle", host_req, 1);
    host_busy = 1'b1;
    @(negedge clk);
    chk("R10 host_req dropped once taken", host_req, 0);
    @(negedge clk);
    host_busy = 1'b0;
    @(negedge clk);
    chk("R11 busy released after host done", busy, 0);
  endtask

  initial begin
    do_init(DISK_A);

    // table walk: R3 R4 R5 R6 R7 R12
    foreach (VEC[i]) begin
      logic [2:0]  vc = VEC[i][36:34];
      logic [1:0]  vm = VEC[i][33:32];
      logic [15:0] vf = VEC[i][31:16];
      logic [15:0] vn = VEC[i][15:0];
      string tg;
      size_code = vc;
      @(negedge clk);
      chk("R4 capacity for size code", max_files, expect_cap(DISK_A, int'(vc)));
      tg = (vm == 2'b00) ? "R7" : (vm == 2'b10) ? ((vf == 16'd60000) ? "R12" : "R5") : "R6";
      if (vc == 3'd7) tg = "R3";
      run_cmd(tg, vc, vm, vf, vn);
    end

    // R8 reserved command
    ucmd = 2'b01; first_file = 16'd9; file_count = 16'd9; req = 1'b1;
    @(negedge clk);
    chk("R8 reserved busy", busy, 0);
    chk("R8 reserved host_req", host_req, 0);
    @(negedge clk);
    req = 1'b0;
    chk("R8 reserved still idle", busy, 0);

    // R9 + R11 same-edge case: request held across the finishing edge
    size_code = 3'd0; ucmd = 2'b10; first_file = 16'd2; file_count = 16'd1; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    chk("R5 first command addr", host_addr, BASE_S + 2 * 65536);
    host_busy = 1'b1;
    @(negedge clk);
    ucmd = 2'b11; first_file = 16'd8; file_count = 16'd2; size_code = 3'd1; req = 1'b1;
    @(negedge clk);
    chk("R9 req while busy: host_req", host_req, 0);
    chk("R9 req while busy: addr unchanged", host_addr, BASE_S + 2 * 65536);
    chk("R4 capacity follows code while busy", max_files, expect_cap(DISK_A, 1));
    host_busy = 1'b0;
    @(negedge clk);
    chk("R11 finishing edge busy", busy, 0);
    chk("R11 finishing edge no issue", host_req, 0);
    @(negedge clk);
    req = 1'b0;
    chk("R11 next edge issue busy", busy, 1);
    chk("R11 next edge host_req", host_req, 1);
    chk("R11 next edge addr", host_addr, BASE_S + 8 * 131072);
    chk("R6 read host_cmd", host_cmd, 0);
    host_busy = 1'b1;
    @(negedge clk);
    host_busy = 1'b0;
    @(negedge clk);
    chk("R11 second release", busy, 0);

    // R4 saturation and small disk
    do_init(48'h10_0000_0000);
    size_code = 3'd0;
    @(negedge clk);
    chk("R4 saturate at 65535", max_files, 65535);
    size_code = 3'd6;
    @(negedge clk);
    chk("R4 large disk code 6", max_files, expect_cap(48'h10_0000_0000, 6));
    do_init(48'd1000);
    chk("R4 small disk gives zero", max_files, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule